// File: doc/BRIEF.md
# Timed-Edge D Flip-Flop

This cell is a rising-edge storage element for signals carried in a sub-cycle edge encoding. A fast reference clock defines a grid of cycles. Each encoded signal is a word of `SLOTS` bits per reference cycle, and bit `i` gives the signal level during sub-cycle slot `i`, with bit 0 the earliest slot. A transition sits at slot `i` when bit `i` differs from the slot before it. For slot 0, the slot before is the last slot of the previous reference cycle. The cell watches an encoded clock word and an encoded data word. At every accepted rising clock slot it captures data. In the same reference cycle it drives an encoded output word whose only transitions fall on those capturing slots.

Inside one reference cycle the output word is built combinationally. Storage across cycles goes through a loop-break state machine. Its two states are `HELD_LOW` and `HELD_HIGH`, and they record the output level in the last slot of the cycle. At each reference edge the machine moves to `HELD_HIGH` when that last slot is 1 (transition *settle-high*) and to `HELD_LOW` when it is 0 (transition *settle-low*). Otherwise it stays where it is. The state gives the output level at the start of the next cycle. Two further registers keep the last clock slot and the last data slot, so that an edge at slot 0 can be detected. The clock may carry at most two edges per reference cycle. A word that carries more raises `edge_err`, and only its first two edges in slot order are acted on. With `SLOTS = 1` the cell is an ordinary D flip-flop on the reference grid.

Top module: `tdff_cell`

## Requirements
- R1: While `rst_n` is low, `q_word` is all zeros and `edge_err` is 0, whatever the inputs. After release, the state is `HELD_LOW` and the stored last-slot clock and data levels are 0.
- R2: A rising clock edge at slot `i` (`c_word[i]`=1 with the previous slot 0) makes `q_word` slots `i` and above equal the captured data level. This holds up to the next accepted rising edge, and the change is visible in the same reference cycle.
- R3: `q_word` slots that lie before the first accepted rising edge of a cycle equal the previous cycle's `q_word[SLOTS-1]`.
- R4: The data level captured at slot `i` is the level of the slot just before it (`d_word[i-1]`, or the previous cycle's `d_word[SLOTS-1]` when `i`=0). A data change at the same slot as the clock edge is therefore not captured.
- R5: Edge detection at slot 0 uses the previous cycle's last clock slot. A clock that stays high across a reference boundary gives no edge.
- R6: When the clock word carries more than two edges (rising or falling, counted from slot 0 upward), `edge_err` is 1 and every edge after the second is ignored.
- R7: `q_word` changes level between adjacent slots, or between the last slot of one cycle and slot 0 of the next, only at an accepted rising clock edge.
- R8: With `SLOTS` = 1 the cell acts as a plain D flip-flop. In a cycle where the clock bit rises, `q_word` shows the data bit of the previous cycle. Otherwise it keeps its value.
- R9: When the clock word carries two edges or fewer, `edge_err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, one encoded word per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| c_word | input | SLOTS | Encoded clock input, bit 0 earliest slot |
| d_word | input | SLOTS | Encoded data input, bit 0 earliest slot |
| q_word | output | SLOTS | Encoded output, same-cycle result |
| edge_err | output | 1 | Clock word carried more than two edges |

## Verification
The hardest situations to reach are the ones that depend on state carried over from the previous reference cycle. These are a clock edge at slot 0 that exists only because the prior word ended low, and a data capture at slot 0 that reads the prior word's last data bit. The directed sequence sets these up on purpose: it ends one cycle with the clock high or low and the data at the opposite level to the next word's data. The over-limit case is built so that an ignored third or fourth edge would capture a different value than the accepted one. A wrong edge count then shows up directly in `q_word`.

// File: rtl/tdff_pkg.sv
package tdff_pkg;
    localparam int unsigned EDGE_LIMIT = 2;

    typedef enum logic {
        HELD_LOW  = 1'b0,
        HELD_HIGH = 1'b1
    } hold_e;
endpackage

// File: rtl/tdff_edge_scan.sv
module tdff_edge_scan #(
    parameter int unsigned SLOTS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] c_word,
    input  logic             c_last,
    output logic [SLOTS-1:0] acc_rise,
    output logic             over_limit
);
    import tdff_pkg::*;

    logic [SLOTS:0]   c_ext;
    logic [SLOTS-1:0] any_edge;
    logic [SLOTS-1:0] rise_raw;
    logic [SLOTS-1:0] acc_edge;

    assign c_ext    = {c_word, c_last};
    assign any_edge = c_word ^ c_ext[SLOTS-1:0];
    assign rise_raw = c_word & ~c_ext[SLOTS-1:0];

    always_comb begin
        int unsigned seen;
        seen       = 0;
        acc_edge   = '0;
        acc_rise   = '0;
        over_limit = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (any_edge[i]) begin
                if (seen < EDGE_LIMIT) begin
                    acc_edge[i] = 1'b1;
                    acc_rise[i] = rise_raw[i];
                end else begin
                    over_limit = 1'b1;
                end
                seen = seen + 1;
            end
        end
    end

    // R6: never more than the allowed number of edges acted on
    a_r6_edge_cap: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(acc_edge) <= EDGE_LIMIT);

    // R9: without an error every detected edge is acted on
    a_r9_all_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !over_limit |-> (acc_edge == any_edge));
endmodule

// File: rtl/tdff_slot_track.sv
module tdff_slot_track #(
    parameter int unsigned SLOTS = 8
) (
    input  logic             held_lvl,
    input  logic [SLOTS-1:0] d_word,
    input  logic             d_last,
    input  logic [SLOTS-1:0] acc_rise,
    output logic [SLOTS-1:0] q_raw
);
    logic [SLOTS:0]   d_ext;
    logic [SLOTS-1:0] d_before;

    assign d_ext    = {d_word, d_last};
    assign d_before = d_ext[SLOTS-1:0];

    always_comb begin
        logic lvl;
        lvl = held_lvl;
        for (int i = 0; i < SLOTS; i++) begin
            if (acc_rise[i]) begin
                lvl = d_before[i];
            end
            q_raw[i] = lvl;
        end
    end
endmodule

// File: rtl/tdff_cell.sv
module tdff_cell #(
    parameter int unsigned SLOTS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] c_word,
    input  logic [SLOTS-1:0] d_word,
    output logic [SLOTS-1:0] q_word,
    output logic             edge_err
);
    import tdff_pkg::*;

    localparam int unsigned LAST = SLOTS - 1;

    hold_e            state_q;
    hold_e            state_d;
    logic             held_lvl;
    logic             c_last_q;
    logic             d_last_q;
    logic [SLOTS-1:0] acc_rise;
    logic [SLOTS-1:0] q_raw;
    logic             over_limit;

    tdff_edge_scan #(.SLOTS(SLOTS)) scan_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .c_word     (c_word),
        .c_last     (c_last_q),
        .acc_rise   (acc_rise),
        .over_limit (over_limit)
    );

    tdff_slot_track #(.SLOTS(SLOTS)) track_i (
        .held_lvl (held_lvl),
        .d_word   (d_word),
        .d_last   (d_last_q),
        .acc_rise (acc_rise),
        .q_raw    (q_raw)
    );

    // loop-break state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= HELD_LOW;
            c_last_q <= 1'b0;
            d_last_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            c_last_q <= c_word[LAST];
            d_last_q <= d_word[LAST];
        end
    end

    // next state: settle-high / settle-low from the final slot
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HELD_LOW:  if (q_raw[LAST])  state_d = HELD_HIGH;
            HELD_HIGH: if (!q_raw[LAST]) state_d = HELD_LOW;
            default:   state_d = HELD_LOW;
        endcase
    end

    // outputs
    always_comb begin
        held_lvl = 1'b0;
        unique case (state_q)
            HELD_LOW:  held_lvl = 1'b0;
            HELD_HIGH: held_lvl = 1'b1;
            default:   held_lvl = 1'b0;
        endcase
        q_word   = rst_n ? q_raw : '0;
        edge_err = rst_n & over_limit;
    end

    // R1: first cycle after release starts from a low held level
    a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_q == HELD_LOW));

    // R3: slot 0 continues the previous final slot unless clocked there
    a_r3_carry_level: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (acc_rise[0] || (q_word[0] == $past(q_word[LAST]))));

    // R4/R5: capture at slot 0 reads the previous cycle's last data slot
    a_r4_slot0_sample: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (!acc_rise[0] || (q_word[0] == $past(d_word[LAST]))));

    generate
        for (genvar g = 1; g < SLOTS; g++) begin : g_slot_chk
            // R7: level changes only at an accepted rising slot
            a_r7_change_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
                (q_word[g] != q_word[g-1]) |-> acc_rise[g]);
            // R2/R4: a capture takes the data of the preceding slot
            a_r2_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
                acc_rise[g] |-> (q_word[g] == d_word[g-1]));
        end
    endgenerate
endmodule

// File: tb/tdff_cell_tb_top.sv
module tdff_cell_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] c_word = '0;
    logic [7:0] d_word = '0;
    logic [7:0] q_word;
    logic       edge_err;
    logic [0:0] c1 = '0;
    logic [0:0] d1 = '0;
    logic [0:0] q1;
    logic       err1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    tdff_cell #(.SLOTS(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .c_word(c_word), .d_word(d_word),
        .q_word(q_word), .edge_err(edge_err)
    );

    tdff_cell #(.SLOTS(1)) dut1_i (
        .clk(clk), .rst_n(rst_n), .c_word(c1), .d_word(d1),
        .q_word(q1), .edge_err(err1)
    );

    task automatic check8(input string req, input logic [7:0] exp_q, input logic exp_e);
        checks++;
        if (q_word !== exp_q || edge_err !== exp_e) begin
            fails++;
            $display("FAIL %s: q_word=%b edge_err=%b expected q_word=%b edge_err=%b",
                     req, q_word, edge_err, exp_q, exp_e);
        end
    endtask

    task automatic cycle8(input string req, input logic [7:0] c, input logic [7:0] d,
                          input logic [7:0] exp_q, input logic exp_e);
        @(negedge clk);
        c_word = c;
        d_word = d;
        #4;
        check8(req, exp_q, exp_e);
    endtask

    task automatic cycle1(input string req, input logic c, input logic d, input logic exp_q);
        @(negedge clk);
        c1 = c;
        d1 = d;
        #4;
        checks++;
        if (q1 !== exp_q || err1 !== 1'b0) begin
            fails++;
            $display("FAIL %s: q=%b err=%b expected q=%b err=0", req, q1, err1, exp_q);
        end
    endtask

    task automatic t_reset;
        c_word = 8'hFF;
        d_word = 8'hFF;
        repeat (2) @(negedge clk);
        #4;
        check8("R1 during reset", 8'h00, 1'b0);
        c_word = 8'h00;
        d_word = 8'h00;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_main;
        cycle8("R3 idle after reset", 8'h00, 8'hFF, 8'h00, 1'b0);
        cycle8("R2 capture high at slot4", 8'b0001_0000, 8'hFF, 8'hF0, 1'b0);
        cycle8("R3 held high carried", 8'h00, 8'h00, 8'hFF, 1'b0);
        cycle8("R4 same-slot data change ignored", 8'b0000_0100, 8'b1111_1100, 8'h03, 1'b0);
        cycle8("R2 capture at last slot", 8'b1000_0000, 8'hFF, 8'h80, 1'b0);
        cycle8("R5 clock held high no edge", 8'hFF, 8'h00, 8'hFF, 1'b0);
        cycle8("R9 fall then rise two edges", 8'b1111_1110, 8'h00, 8'h01, 1'b0);
        cycle8("R6 fourth edge ignored", 8'b0001_0100, 8'b1111_1000, 8'h00, 1'b1);
        cycle8("R6 capture with extra edges", 8'b0010_1010, 8'b0000_0001, 8'hFE, 1'b1);
        cycle8("R5 slot0 rise uses prior data low", 8'b0000_0001, 8'hFF, 8'h00, 1'b0);
        cycle8("R4 slot0 rise uses prior data high", 8'b0000_0001, 8'h00, 8'hFF, 1'b0);
        cycle8("R7 steady without clock", 8'h00, 8'hA5, 8'hFF, 1'b0);
    endtask

    task automatic t_midreset;
        @(negedge clk);
        c_word = 8'b0010_1010;
        d_word = 8'hFF;
        rst_n  = 1'b0;
        #4;
        check8("R1 async reset forces low", 8'h00, 1'b0);
        c_word = 8'h00;
        d_word = 8'h00;
        @(negedge clk);
        rst_n = 1'b1;
        cycle8("R1 held level cleared", 8'h00, 8'h00, 8'h00, 1'b0);
    endtask

    task automatic t_single;
        cycle1("R8 no edge keeps zero", 1'b0, 1'b1, 1'b0);
        cycle1("R8 rise shows previous data", 1'b1, 1'b0, 1'b1);
        cycle1("R8 falling clock holds", 1'b0, 1'b0, 1'b1);
        cycle1("R8 rise captures zero", 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_main();
        t_midreset();
        t_single();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule